// File: doc/BRIEF.md
# Sigma-Delta Converter Serial Reader

This block is the host-side controller for a sigma-delta converter with one output line. That line first signals that a result is ready and then carries the serial data. The controller owns the converter's power-down/reset, gain-select and filter-select pins. When the converter is released from power-down, the controller waits a programmable start-up time. It then watches the line for a falling edge and clocks out one 32-bit word. The word is split into a 24-bit conversion result and an 8-bit status byte, and both are presented to a consumer on a valid/ready handshake.

The converter resets its serial interface at every new update. Each transfer therefore has to finish inside one update period, and that period depends on the filter selection. A watchdog window enforces this limit and flags an overrun when a transfer runs too long. A programmable pause can be inserted after every byte of the transfer. A result that arrives while the previous one is still unaccepted is discarded, and a sticky flag records the loss.

The state machine has these states:
- `ST_OFF`: powered down.
- `ST_WAKE`: start-up wait.
- `ST_WAIT`: armed for a ready edge.
- `ST_CLK_LO`: serial clock low phase.
- `ST_CLK_HI`: serial clock high phase, ending in the bit capture.
- `ST_GAP`: inter-byte pause.
- `ST_PUBLISH`: hand the word to the output.

Its transitions are:
- OFF→WAKE when power is enabled.
- WAKE→WAIT after `STARTUP_CYC` cycles.
- WAIT→CLK_LO on a falling edge of the line.
- CLK_LO→CLK_HI after `CLK_DIV` cycles.
- CLK_HI→CLK_LO, →GAP after bits 8, 16 and 24, or →PUBLISH after bit 32.
- GAP→CLK_LO after `GAP_CYC` cycles.
- PUBLISH→WAIT.
- Any transfer state→WAIT when the overrun window expires.
- Any state→OFF when power is disabled.

Top module: `sdr_reader`

## Requirements
- R1: While `pwr_en_i` is low, `adc_pd_rst_n_o` is low and `adc_sclk_o` stays high. A falling edge on `adc_line_i` starts no transfer. The `overrun_o` and `dropped_o` flags are cleared.
- R2: `adc_gain_unity_o` (1 = gain 1, 0 = gain 128) and `adc_filt_slow_o` (1 = 10 Hz, 0 = 16.7 Hz) take the values of `cfg_gain_unity_i` and `cfg_filt_slow_i` while powered down. They hold those values while powered up.
- R3: For `STARTUP_CYC` cycles after `adc_pd_rst_n_o` rises, no ready indication is accepted and no serial clock pulse is produced.
- R4: A ready is a high-to-low transition of the synchronised line seen in `ST_WAIT`. A line that is already low when waiting begins is ignored until it goes high and falls again.
- R5: A transfer has exactly 32 low pulses on `adc_sclk_o`, which idles high. Each phase lasts `CLK_DIV` cycles. The bit is captured at the end of each high phase and shifted in MSB first.
- R6: When `GAP_CYC` > 0, `adc_sclk_o` is held high for an extra `GAP_CYC` cycles after the 8th, 16th and 24th bits.
- R7: `res_data_o` holds bits 31..8 of the received word and `res_status_o` holds bits 7..0. `res_gain_unity_o` holds the gain setting in force during that read.
- R8: If 32 bits are not captured within the window, the transfer is aborted, `overrun_o` is set (sticky) and no result is published. The window is `SLOW_PERIOD_CYC` cycles when `adc_filt_slow_o` = 1 and `FAST_PERIOD_CYC` cycles otherwise, counted from the first clock low phase.
- R9: `res_valid_o` and the result fields stay unchanged until a cycle with `res_ready_i` high. After such a cycle, `res_valid_o` clears.
- R10: A word completing while `res_valid_o` is high and `res_ready_i` is low is discarded. The held result is kept and `dropped_o` is set (sticky).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en_i | input | 1 | Power the converter up (1) or hold it in power-down (0) |
| cfg_gain_unity_i | input | 1 | Requested gain: 1 = gain 1, 0 = gain 128 |
| cfg_filt_slow_i | input | 1 | Requested filter: 1 = 10 Hz, 0 = 16.7 Hz |
| adc_pd_rst_n_o | output | 1 | Converter power-down/reset, active low |
| adc_gain_unity_o | output | 1 | Gain-select pin |
| adc_filt_slow_o | output | 1 | Filter-select pin |
| adc_sclk_o | output | 1 | Serial clock, idles high |
| adc_line_i | input | 1 | Shared data-ready / serial data line |
| res_data_o | output | 24 | Conversion result |
| res_status_o | output | 8 | Status byte of the same word |
| res_gain_unity_o | output | 1 | Gain setting used for this result |
| res_valid_o | output | 1 | Result held and valid |
| res_ready_i | input | 1 | Consumer accepts the result |
| overrun_o | output | 1 | Sticky: a transfer exceeded the update period |
| dropped_o | output | 1 | Sticky: a result was discarded while one was held |

## Verification
The embedded assertions check the following on every cycle:
- a quiet serial clock during power-down;
- frozen gain and filter pins while powered;
- no clock pulse directly after the start-up state;
- the handshake hold rule;
- the stickiness of both error flags;
- the bound on the bit counter.

Other behaviours only the directed scenarios can show:
- the start-up blanking of an early ready;
- rejection of a level-low line;
- the MSB-first split of specific words;
- the inter-byte pause length;
- the overrun produced by the shorter fast-filter window against the longer slow one;
- keeping the first word when a second arrives unaccepted.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_WAKE,
        ST_WAIT,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_GAP,
        ST_PUBLISH
    } sdr_state_e;
endpackage

// File: rtl/sdr_sync.sv
module sdr_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sdr_count.sv
module sdr_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else          cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sdr_reader.sv
module sdr_reader
    import sdr_pkg::*;
#(
    parameter int CLK_DIV         = 4,
    parameter int STARTUP_CYC     = 200000,
    parameter int FAST_PERIOD_CYC = 12000000,
    parameter int SLOW_PERIOD_CYC = 20000000,
    parameter int GAP_CYC         = 0,
    parameter int WORD_W          = 32,
    parameter int STAT_W          = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_en_i,
    input  logic              cfg_gain_unity_i,
    input  logic              cfg_filt_slow_i,
    output logic              adc_pd_rst_n_o,
    output logic              adc_gain_unity_o,
    output logic              adc_filt_slow_o,
    output logic              adc_sclk_o,
    input  logic              adc_line_i,
    output logic [WORD_W-STAT_W-1:0] res_data_o,
    output logic [STAT_W-1:0] res_status_o,
    output logic              res_gain_unity_o,
    output logic              res_valid_o,
    input  logic              res_ready_i,
    output logic              overrun_o,
    output logic              dropped_o
);
    localparam int DATA_W = WORD_W - STAT_W;
    localparam int BIT_W  = $clog2(WORD_W + 1);
    localparam int MAX_A  = (STARTUP_CYC > SLOW_PERIOD_CYC) ? STARTUP_CYC : SLOW_PERIOD_CYC;
    localparam int MAX_B  = (FAST_PERIOD_CYC > GAP_CYC) ? FAST_PERIOD_CYC : GAP_CYC;
    localparam int MAX_V  = ((MAX_A > MAX_B) ? MAX_A : MAX_B) + CLK_DIV;
    localparam int TW     = $clog2(MAX_V + 1);
    localparam logic [TW-1:0] DIV_LAST  = TW'(CLK_DIV - 1);
    localparam logic [TW-1:0] WAKE_LAST = TW'(STARTUP_CYC - 1);
    localparam logic [TW-1:0] GAP_LAST  = TW'((GAP_CYC > 0) ? GAP_CYC - 1 : 0);
    localparam logic [TW-1:0] FAST_LAST = TW'(FAST_PERIOD_CYC - 1);
    localparam logic [TW-1:0] SLOW_LAST = TW'(SLOW_PERIOD_CYC - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    sdr_state_e state_q, state_d;
    logic [TW-1:0]     phase_cnt, win_cnt;
    logic [BIT_W-1:0]  bit_q;
    logic [WORD_W-1:0] shreg;
    logic              line_s, line_prev, line_fall;
    logic              in_xfer, win_hit, bit_end, group_end;

    // line synchroniser and falling-edge detector
    sdr_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(adc_line_i), .q(line_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_prev <= 1'b1;
        else        line_prev <= line_s;
    end
    assign line_fall = line_prev & ~line_s;

    // cycles spent in the current state
    sdr_count #(.W(TW)) u_phase (
        .clk(clk), .rst_n(rst_n), .clr(state_d != state_q), .cnt(phase_cnt)
    );

    // transfer window, held at zero while armed
    sdr_count #(.W(TW)) u_window (
        .clk(clk), .rst_n(rst_n), .clr(state_q == ST_WAIT), .cnt(win_cnt)
    );

    assign in_xfer   = (state_q == ST_CLK_LO) || (state_q == ST_CLK_HI) || (state_q == ST_GAP);
    assign win_hit   = win_cnt >= (adc_filt_slow_o ? SLOW_LAST : FAST_LAST);
    assign bit_end   = (state_q == ST_CLK_HI) && (phase_cnt == DIV_LAST);
    assign group_end = (GAP_CYC > 0) && (bit_q[2:0] == 3'b111);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:     if (pwr_en_i) state_d = ST_WAKE;
            ST_WAKE:    if (phase_cnt == WAKE_LAST) state_d = ST_WAIT;
            ST_WAIT:    if (line_fall) state_d = ST_CLK_LO;
            ST_CLK_LO:  if (phase_cnt == DIV_LAST) state_d = ST_CLK_HI;
            ST_CLK_HI: begin
                if (bit_end) begin
                    if (bit_q == LAST_BIT) state_d = ST_PUBLISH;
                    else if (group_end)    state_d = ST_GAP;
                    else                   state_d = ST_CLK_LO;
                end
            end
            ST_GAP:     if (phase_cnt == GAP_LAST) state_d = ST_CLK_LO;
            ST_PUBLISH: state_d = ST_WAIT;
            default:    state_d = ST_OFF;
        endcase
        if (in_xfer && win_hit) state_d = ST_WAIT;
        if (!pwr_en_i)          state_d = ST_OFF;
    end

    // pin outputs decoded from the state register
    always_comb begin
        adc_pd_rst_n_o = (state_q != ST_OFF);
        adc_sclk_o     = (state_q != ST_CLK_LO);
    end

    // datapath: configuration, shifter, result holding, flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adc_gain_unity_o <= 1'b0;
            adc_filt_slow_o  <= 1'b0;
            bit_q            <= '0;
            shreg            <= '0;
            res_data_o       <= '0;
            res_status_o     <= '0;
            res_gain_unity_o <= 1'b0;
            res_valid_o      <= 1'b0;
            overrun_o        <= 1'b0;
            dropped_o        <= 1'b0;
        end else begin
            if (state_q == ST_OFF) begin
                adc_gain_unity_o <= cfg_gain_unity_i;
                adc_filt_slow_o  <= cfg_filt_slow_i;
                overrun_o        <= 1'b0;
                dropped_o        <= 1'b0;
            end
            if (state_q == ST_WAIT) bit_q <= '0;
            if (bit_end && !win_hit) begin
                shreg <= {shreg[WORD_W-2:0], line_s};
                bit_q <= bit_q + 1'b1;
            end
            if (in_xfer && win_hit && pwr_en_i) overrun_o <= 1'b1;
            if (res_valid_o && res_ready_i) res_valid_o <= 1'b0;
            if (state_q == ST_PUBLISH) begin
                if (res_valid_o && !res_ready_i) begin
                    dropped_o <= 1'b1;
                end else begin
                    res_data_o       <= shreg[WORD_W-1:STAT_W];
                    res_status_o     <= shreg[STAT_W-1:0];
                    res_gain_unity_o <= adc_gain_unity_o;
                    res_valid_o      <= 1'b1;
                end
            end
        end
    end

    // R1
    pd_sclk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_pd_rst_n_o |-> adc_sclk_o);

    // R2
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_pd_rst_n_o && pwr_en_i) |=> ($stable(adc_gain_unity_o) && $stable(adc_filt_slow_o)));

    // R3
    wake_no_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAKE) |=> (state_q != ST_CLK_LO));

    // R5
    bit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_q <= BIT_W'(WORD_W));

    // R8
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_o && adc_pd_rst_n_o && pwr_en_i) |=> overrun_o);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && !res_ready_i) |=>
            (res_valid_o && $stable(res_data_o) && $stable(res_status_o) && $stable(res_gain_unity_o)));

    // R10
    dropped_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dropped_o && adc_pd_rst_n_o && pwr_en_i) |=> dropped_o);

    initial begin
        // R5
        div_param_chk: assert (CLK_DIV >= 4 && DATA_W > 0);
    end
endmodule

// File: tb/sim_sdr_reader.sv
module sim_sdr_reader;
    localparam int DIV  = 4;
    localparam int WAKE = 50;
    localparam int FAST = 500;
    localparam int SLOW = 1000;
    localparam int GAP  = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_en = 1'b0;
    logic cfg_gain = 1'b0;
    logic cfg_filt = 1'b0;
    logic res_ready = 1'b0;
    logic line = 1'b1;
    logic pd_n, gain_o, filt_o, sclk;
    logic [23:0] rdata;
    logic [7:0]  rstat;
    logic rgain, rvalid, ovr, drop;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] stub_word = '0;
    int  stub_idx = 32;
    int  sclk_falls = 0;
    int  hi_run = 0;
    int  hi_max = 0;

    always #2.5 clk = ~clk;

    sdr_reader #(
        .CLK_DIV(DIV), .STARTUP_CYC(WAKE), .FAST_PERIOD_CYC(FAST),
        .SLOW_PERIOD_CYC(SLOW), .GAP_CYC(GAP), .WORD_W(32), .STAT_W(8)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_en_i(pwr_en),
        .cfg_gain_unity_i(cfg_gain), .cfg_filt_slow_i(cfg_filt),
        .adc_pd_rst_n_o(pd_n), .adc_gain_unity_o(gain_o), .adc_filt_slow_o(filt_o),
        .adc_sclk_o(sclk), .adc_line_i(line),
        .res_data_o(rdata), .res_status_o(rstat), .res_gain_unity_o(rgain),
        .res_valid_o(rvalid), .res_ready_i(res_ready),
        .overrun_o(ovr), .dropped_o(drop)
    );

    // converter stub: next bit on each serial clock falling edge
    always @(negedge sclk) begin
        sclk_falls = sclk_falls + 1;
        if (stub_idx < 32) begin
            line = stub_word[31 - stub_idx];
            stub_idx = stub_idx + 1;
        end
    end

    // longest high run of the serial clock between bits of a transfer
    always @(negedge clk) begin
        if (sclk) hi_run = hi_run + 1;
        else begin
            if (stub_idx >= 2 && hi_run > hi_max) hi_max = hi_run;
            hi_run = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic present(input logic [31:0] w);
        line = 1'b1;
        cycles(10);
        stub_word = w;
        stub_idx = 0;
        sclk_falls = 0;
        hi_max = 0;
        line = 1'b0;
    endtask

    task automatic wait_valid(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (rvalid) begin seen = 1'b1; break; end
        end
    endtask

    task automatic power_up(input logic g, input logic f);
        pwr_en = 1'b0;
        cfg_gain = g;
        cfg_filt = f;
        cycles(5);
        pwr_en = 1'b1;
    endtask

    task automatic t_reset;
        chk(pd_n == 1'b0, "R1 reset pd", 32'(pd_n), 0);
        chk(sclk == 1'b1, "R1 reset sclk", 32'(sclk), 1);
        chk(rvalid == 1'b0, "R9 reset valid", 32'(rvalid), 0);
    endtask

    task automatic t_powerdown_ignore;
        sclk_falls = 0;
        line = 1'b0;
        cycles(60);
        chk(sclk_falls == 0, "R1 edge ignored in power-down", 32'(sclk_falls), 0);
        chk(rvalid == 1'b0, "R1 no result in power-down", 32'(rvalid), 0);
        line = 1'b1;
        cycles(5);
    endtask

    task automatic t_startup;
        power_up(1'b1, 1'b1);
        cycles(2);
        chk(gain_o == 1'b1 && filt_o == 1'b1, "R2 config applied", {30'd0, gain_o, filt_o}, 3);
        sclk_falls = 0;
        cycles(10);
        line = 1'b0;
        cycles(WAKE + 40);
        // r3_ / r4_: edge inside start-up, still low afterwards
        chk(sclk_falls == 0, "R3 R4 early ready ignored", 32'(sclk_falls), 0);
        cfg_gain = 1'b0;
        cfg_filt = 1'b0;
        cycles(5);
        chk(gain_o == 1'b1 && filt_o == 1'b1, "R2 config held while powered", {30'd0, gain_o, filt_o}, 3);
    endtask

    task automatic t_read;
        bit seen;
        present(32'hA5C3_1E96);
        wait_valid(seen);
        chk(seen, "R4 R5 read completes", 32'(seen), 1);
        chk(sclk_falls == 32, "R5 32 clock pulses", 32'(sclk_falls), 32);
        chk(rdata == 24'hA5C31E, "R7 result field", 32'(rdata), 32'hA5C31E);
        chk(rstat == 8'h96, "R7 status field", 32'(rstat), 32'h96);
        chk(rgain == 1'b1, "R7 gain tag", 32'(rgain), 1);
        chk(hi_max >= GAP && hi_max <= GAP + 2 * DIV, "R6 inter-byte pause", 32'(hi_max), GAP + DIV);
        cycles(20);
        chk(rvalid && rdata == 24'hA5C31E, "R9 held without ready", 32'(rdata), 32'hA5C31E);
        res_ready = 1'b1;
        cycles(1);
        res_ready = 1'b0;
        cycles(1);
        chk(rvalid == 1'b0, "R9 cleared after accept", 32'(rvalid), 0);
        chk(ovr == 1'b0, "R8 slow window no overrun", 32'(ovr), 0);
    endtask

    task automatic t_dropped;
        bit seen;
        present(32'h1234_5601);
        wait_valid(seen);
        chk(rdata == 24'h123456 && rstat == 8'h01, "R7 second word", 32'(rdata), 32'h123456);
        present(32'hFEDC_BA10);
        cycles(800);
        chk(drop == 1'b1, "R10 dropped flag", 32'(drop), 1);
        chk(rdata == 24'h123456, "R10 held result kept", 32'(rdata), 32'h123456);
        res_ready = 1'b1;
        cycles(1);
        res_ready = 1'b0;
        cycles(5);
        chk(drop == 1'b1, "R10 flag sticky", 32'(drop), 1);
    endtask

    task automatic t_overrun;
        power_up(1'b0, 1'b0);
        cycles(2);
        chk(drop == 1'b0 && ovr == 1'b0, "R1 flags cleared by power-down", {30'd0, drop, ovr}, 0);
        chk(gain_o == 1'b0 && filt_o == 1'b0, "R2 new config", {30'd0, gain_o, filt_o}, 0);
        cycles(WAKE + 10);
        present(32'h0F0F_0F0F);
        cycles(800);
        chk(ovr == 1'b1, "R8 fast window overrun", 32'(ovr), 1);
        chk(rvalid == 1'b0, "R8 no result after overrun", 32'(rvalid), 0);
        chk(sclk_falls < 32, "R8 transfer aborted", 32'(sclk_falls), 31);
    endtask

    initial begin
        cycles(4);
        rst_n = 1'b1;
        cycles(2);
        t_reset();
        t_powerdown_ignore();
        t_startup();
        t_read();
        t_dropped();
        t_overrun();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule